// File: doc/BRIEF.md
# CPU status flag register

This block is the eight-bit processor status word of a small microcontroller core. It holds the global interrupt enable, a one-bit transfer cell used by bit-store and bit-load instructions, and six arithmetic condition flags. The ALU presents freshly computed flag values together with a per-flag enable. Interrupt control strobes come from the sequencer. A bit-store operation captures one chosen bit of a register operand. A whole-register write port lets software load the word directly.

The ALU, instruction decode and context saving sit outside this block. Nothing is pushed or popped on interrupt entry or return; the word changes only through the operations listed below. Every output comes straight from the register, so each operation becomes visible one clock after it is presented.

Top module: `cpu_status_reg`

## Requirements
- R1: The word holds, from bit 7 down to bit 0: I (interrupt enable), T (copy bit), H, S, V, N, Z, C. After reset all eight bits read 0.
- R2: When `wr_en` is high, the next word equals `wr_data` exactly, including an S bit that differs from N xor V. Every other operation in that cycle is ignored.
- R3: When `irq_take` is high and `wr_en` is low, I becomes 0, even if a return or set strobe is also present.
- R4: When `irq_return` or `ie_set` is high and neither `wr_en` nor `irq_take` is, I becomes 1. This holds even if `ie_clr` is also high.
- R5: When `ie_clr` is the only interrupt-control strobe and `wr_en` is low, I becomes 0.
- R6: `alu_flag_en` and `alu_flag_val` use bit 4=H, 3=V, 2=N, 1=Z, 0=C. With `wr_en` low, each enabled flag takes its value and each disabled flag keeps its old value.
- R7: After any cycle with at least one flag enable set and `wr_en` low, S equals N xor V of the new word.
- R8: When `bst_en` is high and `wr_en` is low, T takes bit `bit_sel` (0 to 7) of `bst_operand`.
- R9: `bld_bit` always presents T, and `gie` always presents I. When I is 0, `gie` is 0.
- R10: In a cycle with no write, no interrupt strobe, no flag enable and no bit-store, all eight bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Whole-word write strobe |
| wr_data | input | 8 | Word to write |
| irq_take | input | 1 | Interrupt accepted |
| irq_return | input | 1 | Return from interrupt |
| ie_set | input | 1 | Force I to 1 |
| ie_clr | input | 1 | Force I to 0 |
| alu_flag_val | input | 5 | New H,V,N,Z,C values from the ALU |
| alu_flag_en | input | 5 | Per-flag update enables |
| bst_en | input | 1 | Bit-store strobe |
| bst_operand | input | 8 | Register operand for bit-store |
| bit_sel | input | 3 | Bit index for bit-store |
| status_q | output | 8 | Current status word |
| gie | output | 1 | Global interrupt enable |
| bld_bit | output | 1 | Copy bit for bit-load |

## Verification
Some rules are checked on every cycle by the assertions. These are the write override, the priority of the interrupt-control strobes, S following N xor V after a flag update, the bit-store capture, and holding when nothing is active. Other behaviour only shows in the bench's scenarios. This includes partial flag masks, in which only some flags change. It also includes written words whose S bit disagrees with N xor V, and the routing of the copy bit and interrupt enable to their dedicated outputs across a sequence of operations.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W  = 8;
  localparam int SEL_W  = $clog2(PSR_W);
  localparam int NFLAG  = 5;
  localparam int POS_I  = 7;
  localparam int POS_T  = 6;
  localparam int POS_H  = 5;
  localparam int POS_S  = 4;
  localparam int POS_V  = 3;
  localparam int POS_N  = 2;
  localparam int POS_Z  = 1;
  localparam int POS_C  = 0;
  // positions inside the five-flag ALU vector
  localparam int FV_H = 4;
  localparam int FV_V = 3;
  localparam int FV_N = 2;
  localparam int FV_Z = 1;
  localparam int FV_C = 0;

  function automatic logic sign_of(input logic n, input logic v);
    return n ^ v;
  endfunction

  function automatic logic [NFLAG-1:0] merge_flags(input logic [NFLAG-1:0] old_f,
                                                   input logic [NFLAG-1:0] new_f,
                                                   input logic [NFLAG-1:0] en);
    return (old_f & ~en) | (new_f & en);
  endfunction
endpackage

// File: rtl/psr_ie_ctl.sv
module psr_ie_ctl (
  input  logic ev_wr,
  input  logic wr_bit,
  input  logic irq_take,
  input  logic irq_return,
  input  logic ie_set,
  input  logic ie_clr,
  input  logic cur,
  output logic nxt
);
  always_comb begin
    if (ev_wr)                     nxt = wr_bit;
    else if (irq_take)             nxt = 1'b0;
    else if (irq_return || ie_set) nxt = 1'b1;
    else if (ie_clr)               nxt = 1'b0;
    else                           nxt = cur;
  end
endmodule

// File: rtl/psr_arith_upd.sv
module psr_arith_upd
  import psr_pkg::*;
(
  input  logic [NFLAG-1:0] cur_flags,
  input  logic             cur_s,
  input  logic [NFLAG-1:0] val,
  input  logic [NFLAG-1:0] en,
  output logic [NFLAG-1:0] nxt_flags,
  output logic             nxt_s,
  output logic             upd
);
  always_comb begin
    upd       = |en;
    nxt_flags = merge_flags(cur_flags, val, en);
    nxt_s     = upd ? sign_of(nxt_flags[FV_N], nxt_flags[FV_V]) : cur_s;
  end
endmodule

// File: rtl/psr_bitcopy.sv
module psr_bitcopy
  import psr_pkg::*;
(
  input  logic             cur_t,
  input  logic             bst_en,
  input  logic [PSR_W-1:0] operand,
  input  logic [SEL_W-1:0] sel,
  output logic             nxt_t
);
  always_comb begin
    nxt_t = bst_en ? operand[sel] : cur_t;
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PSR_W-1:0] wr_data,
  input  logic             irq_take,
  input  logic             irq_return,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic [NFLAG-1:0] alu_flag_val,
  input  logic [NFLAG-1:0] alu_flag_en,
  input  logic             bst_en,
  input  logic [PSR_W-1:0] bst_operand,
  input  logic [SEL_W-1:0] bit_sel,
  output logic [PSR_W-1:0] status_q,
  output logic             gie,
  output logic             bld_bit
);
  logic [PSR_W-1:0] word_q;
  logic [PSR_W-1:0] word_d;
  logic             i_nxt;
  logic             t_nxt;
  logic             s_nxt;
  logic [NFLAG-1:0] fl_cur;
  logic [NFLAG-1:0] fl_nxt;

  // named events for the checker
  logic ev_wr;
  logic ev_flag_upd;
  logic ev_bst;
  logic flag_any;

  assign ev_wr       = wr_en;
  assign ev_bst      = bst_en && !wr_en;
  assign ev_flag_upd = flag_any && !wr_en;

  assign fl_cur = {word_q[POS_H], word_q[POS_V], word_q[POS_N],
                   word_q[POS_Z], word_q[POS_C]};

  psr_ie_ctl u_ie (
    .ev_wr      (ev_wr),
    .wr_bit     (wr_data[POS_I]),
    .irq_take   (irq_take),
    .irq_return (irq_return),
    .ie_set     (ie_set),
    .ie_clr     (ie_clr),
    .cur        (word_q[POS_I]),
    .nxt        (i_nxt)
  );

  psr_arith_upd u_ar (
    .cur_flags (fl_cur),
    .cur_s     (word_q[POS_S]),
    .val       (alu_flag_val),
    .en        (alu_flag_en),
    .nxt_flags (fl_nxt),
    .nxt_s     (s_nxt),
    .upd       (flag_any)
  );

  psr_bitcopy u_bc (
    .cur_t   (word_q[POS_T]),
    .bst_en  (bst_en),
    .operand (bst_operand),
    .sel     (bit_sel),
    .nxt_t   (t_nxt)
  );

  always_comb begin
    if (ev_wr) begin
      word_d = wr_data;
    end else begin
      word_d        = '0;
      word_d[POS_I] = i_nxt;
      word_d[POS_T] = t_nxt;
      word_d[POS_H] = fl_nxt[FV_H];
      word_d[POS_S] = s_nxt;
      word_d[POS_V] = fl_nxt[FV_V];
      word_d[POS_N] = fl_nxt[FV_N];
      word_d[POS_Z] = fl_nxt[FV_Z];
      word_d[POS_C] = fl_nxt[FV_C];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign status_q = word_q;
  assign gie      = word_q[POS_I];
  assign bld_bit  = word_q[POS_T];
endmodule

// File: rtl/psr_checker.sv
module psr_checker
  import psr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [PSR_W-1:0] wr_data,
  input logic             irq_take,
  input logic             irq_return,
  input logic             ie_set,
  input logic             ie_clr,
  input logic [NFLAG-1:0] alu_flag_en,
  input logic             bst_en,
  input logic [PSR_W-1:0] bst_operand,
  input logic [SEL_W-1:0] bit_sel,
  input logic [PSR_W-1:0] status_q,
  input logic             gie,
  input logic             ev_wr,
  input logic             ev_flag_upd,
  input logic             ev_bst
);
  a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> status_q == $past(wr_data));

  a_r3_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !wr_en) |=> !gie);

  a_r4_ie_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !irq_take && (irq_return || ie_set)) |=> gie);

  a_r5_ie_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !irq_take && !irq_return && !ie_set && ie_clr) |=> !gie);

  a_r7_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag_upd |=> status_q[POS_S] == (status_q[POS_N] ^ status_q[POS_V]));

  a_r8_bit_store: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bst |=> status_q[POS_T] == $past(bst_operand[bit_sel]));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_wr && !irq_take && !irq_return && !ie_set && !ie_clr &&
     !ev_flag_upd && !ev_bst) |=> $stable(status_q));
endmodule

bind cpu_status_reg psr_checker u_psr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .irq_take    (irq_take),
  .irq_return  (irq_return),
  .ie_set      (ie_set),
  .ie_clr      (ie_clr),
  .alu_flag_en (alu_flag_en),
  .bst_en      (bst_en),
  .bst_operand (bst_operand),
  .bit_sel     (bit_sel),
  .status_q    (status_q),
  .gie         (gie),
  .ev_wr       (ev_wr),
  .ev_flag_upd (ev_flag_upd),
  .ev_bst      (ev_bst)
);

// File: tb/test_cpu_status_reg.sv
`timescale 1ns/1ps
module test_cpu_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       irq_take = 1'b0, irq_return = 1'b0, ie_set = 1'b0, ie_clr = 1'b0;
  logic [4:0] alu_flag_val = '0, alu_flag_en = '0;
  logic       bst_en = 1'b0;
  logic [7:0] bst_operand = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] status_q;
  logic       gie, bld_bit;

  int checks = 0;
  int failures = 0;
  logic [7:0] mdl = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cpu_status_reg i_cpu_status_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_take(irq_take), .irq_return(irq_return), .ie_set(ie_set), .ie_clr(ie_clr),
    .alu_flag_val(alu_flag_val), .alu_flag_en(alu_flag_en),
    .bst_en(bst_en), .bst_operand(bst_operand), .bit_sel(bit_sel),
    .status_q(status_q), .gie(gie), .bld_bit(bld_bit));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // independent model, written bit by bit from the requirements
  function automatic logic [7:0] model(input logic [7:0] cur);
    logic [7:0] n;
    if (wr_en) return wr_data;
    n = cur;
    if (irq_take) n[7] = 1'b0;
    else if (irq_return | ie_set) n[7] = 1'b1;
    else if (ie_clr) n[7] = 1'b0;
    if (bst_en) n[6] = (bst_operand >> bit_sel) & 8'd1;
    if (alu_flag_en[4]) n[5] = alu_flag_val[4];
    if (alu_flag_en[3]) n[3] = alu_flag_val[3];
    if (alu_flag_en[2]) n[2] = alu_flag_val[2];
    if (alu_flag_en[1]) n[1] = alu_flag_val[1];
    if (alu_flag_en[0]) n[0] = alu_flag_val[0];
    if (alu_flag_en != 5'd0) n[4] = (n[2] != n[3]);
    return n;
  endfunction

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; irq_take = 0; irq_return = 0; ie_set = 0; ie_clr = 0;
    alu_flag_val = '0; alu_flag_en = '0; bst_en = 0; bst_operand = '0; bit_sel = '0;
  endtask

  // driver: inputs already set at the negedge; predict, clock, push
  task automatic step(input string tag);
    mdl = model(mdl);
    @(posedge clk);
    #1;
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
  endtask

  // monitor: compare away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, status_q, e);
      check({t, " R9 gie"}, {7'd0, gie}, {7'd0, e[7]});
      check({t, " R9 bld_bit"}, {7'd0, bld_bit}, {7'd0, e[6]});
    end
  end

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", status_q, 8'h00);
    rst_n = 1;
    @(negedge clk); idle_inputs(); step("R10 idle after reset");
    @(negedge clk); idle_inputs(); wr_en = 1; wr_data = 8'hA5; step("R2 write S as written");
    @(negedge clk); idle_inputs(); step("R10 idle hold");
    @(negedge clk); idle_inputs(); irq_take = 1; step("R3 interrupt entry");
    @(negedge clk); idle_inputs(); ie_set = 1; step("R4 set I");
    @(negedge clk); idle_inputs(); irq_take = 1; ie_set = 1; irq_return = 1; step("R3 entry beats set");
    @(negedge clk); idle_inputs(); irq_return = 1; step("R4 return sets I");
    @(negedge clk); idle_inputs(); ie_clr = 1; step("R5 clear I");
    @(negedge clk); idle_inputs(); ie_set = 1; ie_clr = 1; step("R4 set beats clear");
    @(negedge clk); idle_inputs(); wr_en = 1; wr_data = 8'h1C; irq_take = 1; ie_set = 1;
      alu_flag_en = 5'h1F; alu_flag_val = 5'h00; bst_en = 1; bst_operand = 8'hFF; step("R2 write overrides all");
    @(negedge clk); idle_inputs(); alu_flag_en = 5'h1F; alu_flag_val = 5'b01000; step("R6 R7 all flags V only");
    @(negedge clk); idle_inputs(); alu_flag_en = 5'b00101; alu_flag_val = 5'b11111; step("R6 R7 partial N C");
    @(negedge clk); idle_inputs(); alu_flag_en = 5'b10010; alu_flag_val = 5'b10010; step("R6 R7 H Z only");
    @(negedge clk); idle_inputs(); alu_flag_en = 5'b01000; alu_flag_val = 5'b00000; step("R7 V cleared");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); idle_inputs(); bst_en = 1; bst_operand = 8'b0110_1001 ^ 8'(k << 1); bit_sel = 3'(k);
      step("R8 bit store");
    end
    @(negedge clk); idle_inputs(); bst_en = 1; bst_operand = 8'h80; bit_sel = 3'd7;
      alu_flag_en = 5'b00001; alu_flag_val = 5'b00001; ie_set = 1; step("R8 R6 combined");
    @(negedge clk); idle_inputs(); bst_operand = 8'h00; bit_sel = 3'd7; alu_flag_val = 5'h00;
      wr_data = 8'h00; step("R10 data without strobes");
    @(negedge clk); idle_inputs(); wr_en = 1; wr_data = 8'h5A; step("R2 second write");
    @(negedge clk); idle_inputs(); irq_take = 1; bst_en = 1; bst_operand = 8'h00; bit_sel = 3'd6;
      step("R3 R8 entry with bit store");
    @(negedge clk); idle_inputs(); step("R10 final hold");
    @(negedge clk); idle_inputs();
    @(negedge clk);
    disable watchdog;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule